// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Output Port

This block is the digital output side of a delta-sigma converter. A modulator and filter model outside the block delivers a finished result as two status flags and a data field, together with a one-cycle completion strobe. The port packs these into a 24-bit word. It holds the word and shows that it is ready by pulling the serial data line low while chip select is active. It then shifts the word out, most significant bit first, on the host's serial clock.

The serial clock also acts as the power control. If it stays high long enough, the port goes to sleep and drops any held word. If it then stays low long enough, the port wakes and sends a one-cycle reset to the filter. After a reset or a wake, the first few results come from a filter that has not settled yet, so the port withholds them. The serial data pin is modelled as a data line plus an output enable. Both host inputs are synchronized into the system clock domain before the port acts on them.

Top module: `adc_serial_port`

## Requirements
- R1: The output enable `sdoEn` is high exactly when `csN` is low, with two system clocks of synchronizer delay.
- R2: The word is built as follows: bit 23 is 0, bit 22 is the overrange flag, bit 21 is the oscillation flag, bit 20 is 0. With `DATA_W`=20, bits 19..0 carry the data.
- R3: With `DATA_W`=16, bits 19..16 are 0 and bits 15..0 carry the data.
- R4: While a word is held, `sdoData` shows bit 23 (low, which signals ready). Each falling SCLK edge moves it to the next lower bit, so the host samples each bit while SCLK is high.
- R5: After the 24th falling SCLK edge, `sdoData` returns high. It stays high until another word is loaded.
- R6: A completion strobe that arrives after the first falling SCLK edge of a read is discarded. The read in progress finishes with the old word, and nothing is pending afterwards.
- R7: If `csN` goes high after the first falling edge of a read, the read is abandoned and nothing is held. The next completed conversion is presented.
- R8: A completion strobe that arrives while a word is held but not yet being read replaces that word.
- R9: When the synchronized SCLK stays high for `SLEEP_CYCLES` system clocks, `sleeping` is set. Any held word is dropped, and completion strobes are ignored while asleep.
- R10: When the synchronized SCLK stays low for `WAKE_CYCLES` while asleep, `sleeping` clears and `filtReset` pulses high for exactly one cycle.
- R11: After reset or wake, the first `SETTLE_CONV` (3) completion strobes are discarded. The next one is presented.
- R12: Out of reset, `sleeping` and `filtReset` are low, `sdoData` is high and no word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| convDone | input | 1 | One-cycle strobe: a conversion result is valid |
| ovrFlag | input | 1 | Overrange flag of the result |
| oscFlag | input | 1 | Oscillation-detect flag of the result |
| convData | input | DATA_W | Two's-complement conversion data |
| csN | input | 1 | Active-low chip select (asynchronous) |
| sclkIn | input | 1 | Host serial clock (asynchronous) |
| sdoData | output | 1 | Serial data value |
| sdoEn | output | 1 | Drive enable for the serial data pin |
| sleeping | output | 1 | Port is in sleep |
| filtReset | output | 1 | One-cycle reset to the filter on wake |

## Verification
Some properties are checked on every cycle. These are how the enable follows chip select, that the data line stays quiet while asleep, that the sleep and wake transitions only follow long enough high or low runs on the raw clock pin, and that the filter reset is a single pulse. The bench scenarios cover the rest: the bit order and packing of the word in both data widths, losing a word when a read overlaps a new result, abandoning a read, replacing an unread word, and withholding results while the filter settles.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  localparam int WORD_W = 24;
  localparam int FIELD_W = 20;

  typedef struct packed {
    logic load;
    logic shift;
  } ctlStrobes_t;
endpackage

// File: rtl/adc_port_datapath.sv
module adc_port_datapath
  import adc_port_pkg::*;
#(
  parameter int DATA_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobe,
  input  logic              ovrFlag,
  input  logic              oscFlag,
  input  logic [DATA_W-1:0] convData,
  output logic              msb
);
  localparam int PAD_W = FIELD_W - DATA_W;

  logic [WORD_W-1:0] packed_word;
  logic [WORD_W-1:0] shiftReg;

  generate
    if (PAD_W > 0) begin : g_padded
      assign packed_word = {1'b0, ovrFlag, oscFlag, 1'b0, {PAD_W{1'b0}}, convData};
    end else begin : g_full
      assign packed_word = {1'b0, ovrFlag, oscFlag, 1'b0, convData};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.load) shiftReg <= packed_word;
    else if (strobe.shift) shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
  end

  assign msb = shiftReg[WORD_W-1];
endmodule

// File: rtl/adc_port_ctrl.sv
module adc_port_ctrl
  import adc_port_pkg::*;
#(
  parameter int SLEEP_CYCLES = 20000,
  parameter int WAKE_CYCLES  = 1000,
  parameter int SETTLE_CONV  = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        convDone,
  input  logic        csN,
  input  logic        sclkIn,
  output ctlStrobes_t strobe,
  output logic        holding,
  output logic        driveEn,
  output logic        sleeping,
  output logic        filtReset
);
  localparam int SLW = $clog2(SLEEP_CYCLES + 1);
  localparam int WKW = $clog2(WAKE_CYCLES + 1);
  localparam int BCW = $clog2(WORD_W + 1);
  localparam int STW = $clog2(SETTLE_CONV + 1);

  logic [1:0] sclkSync, csSync;
  logic sclkPrev;
  logic [SLW-1:0] hiCnt;
  logic [WKW-1:0] loCnt;
  logic [BCW-1:0] bitCnt;
  logic [STW-1:0] settleCnt;

  logic sclkS, csHigh, sclkFall, reading, settled;
  logic sleepNow, wakeNow, lastFall, abortRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[0], sclkIn};
      csSync   <= {csSync[0], csN};
      sclkPrev <= sclkSync[1];
    end
  end

  assign sclkS     = sclkSync[1];
  assign csHigh    = csSync[1];
  assign driveEn   = !csHigh;
  assign sclkFall  = !sclkS && sclkPrev;
  assign reading   = holding && (bitCnt != '0);
  assign settled   = (settleCnt == STW'(SETTLE_CONV));
  assign sleepNow  = !sleeping && sclkS && (hiCnt == SLW'(SLEEP_CYCLES - 1));
  assign wakeNow   = sleeping && !sclkS && (loCnt == WKW'(WAKE_CYCLES - 1));
  assign abortRead = csHigh && reading;

  always_comb begin
    strobe.load  = convDone && !sleeping && settled && !reading && !sleepNow;
    strobe.shift = holding && !csHigh && sclkFall;
    lastFall     = strobe.shift && (bitCnt == BCW'(WORD_W - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiCnt <= '0;
      loCnt <= '0;
    end else begin
      if (!sclkS) hiCnt <= '0;
      else if (hiCnt != SLW'(SLEEP_CYCLES - 1)) hiCnt <= hiCnt + 1'b1;
      if (!sleeping || sclkS) loCnt <= '0;
      else if (loCnt != WKW'(WAKE_CYCLES - 1)) loCnt <= loCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleeping  <= 1'b0;
      filtReset <= 1'b0;
      settleCnt <= '0;
    end else begin
      filtReset <= wakeNow;
      if (sleepNow) sleeping <= 1'b1;
      else if (wakeNow) sleeping <= 1'b0;
      if (wakeNow) settleCnt <= '0;
      else if (convDone && !sleeping && !settled) settleCnt <= settleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holding <= 1'b0;
      bitCnt  <= '0;
    end else if (sleepNow) begin
      holding <= 1'b0;
      bitCnt  <= '0;
    end else if (strobe.load) begin
      holding <= 1'b1;
      bitCnt  <= '0;
    end else if (abortRead || lastFall) begin
      holding <= 1'b0;
      bitCnt  <= '0;
    end else if (strobe.shift) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_port_pkg::*;
#(
  parameter int DATA_W       = 20,
  parameter int SLEEP_CYCLES = 20000,
  parameter int WAKE_CYCLES  = 1000,
  parameter int SETTLE_CONV  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic              ovrFlag,
  input  logic              oscFlag,
  input  logic [DATA_W-1:0] convData,
  input  logic              csN,
  input  logic              sclkIn,
  output logic              sdoData,
  output logic              sdoEn,
  output logic              sleeping,
  output logic              filtReset
);
  ctlStrobes_t strobe;
  logic holding, msb;

  adc_port_ctrl #(
    .SLEEP_CYCLES(SLEEP_CYCLES),
    .WAKE_CYCLES (WAKE_CYCLES),
    .SETTLE_CONV (SETTLE_CONV)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .convDone (convDone),
    .csN      (csN),
    .sclkIn   (sclkIn),
    .strobe   (strobe),
    .holding  (holding),
    .driveEn  (sdoEn),
    .sleeping (sleeping),
    .filtReset(filtReset)
  );

  adc_port_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .ovrFlag (ovrFlag),
    .oscFlag (oscFlag),
    .convData(convData),
    .msb     (msb)
  );

  assign sdoData = holding ? msb : 1'b1;
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
  parameter int SLEEP_CYCLES = 20000,
  parameter int WAKE_CYCLES  = 1000
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclkIn,
  input logic sdoData,
  input logic sdoEn,
  input logic sleeping,
  input logic filtReset
);
  logic [1:0]  sinceRst;
  logic [31:0] hiRun, hiRunD1, hiRunD2;
  logic [31:0] loRun, loRunD1, loRunD2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      hiRun <= '0; hiRunD1 <= '0; hiRunD2 <= '0;
      loRun <= '0; loRunD1 <= '0; loRunD2 <= '0;
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
      hiRun <= sclkIn ? ((hiRun == 32'hFFFF_FFFF) ? hiRun : hiRun + 1) : '0;
      loRun <= !sclkIn ? ((loRun == 32'hFFFF_FFFF) ? loRun : loRun + 1) : '0;
      hiRunD1 <= hiRun; hiRunD2 <= hiRunD1;
      loRunD1 <= loRun; loRunD2 <= loRunD1;
    end
  end

  AST_EN_TRACKS_CS: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (sdoEn == !$past(csN, 2))); // R1

  AST_QUIET_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    sleeping |-> sdoData); // R9

  AST_SLEEP_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleeping) |-> (hiRunD2 >= 32'(SLEEP_CYCLES))); // R9

  AST_WAKE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleeping) |-> (loRunD2 >= 32'(WAKE_CYCLES))); // R10

  AST_FILT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    filtReset |=> !filtReset); // R10

  AST_FILT_ON_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    filtReset |-> (!sleeping && $past(sleeping, 2))); // R10
endmodule

bind adc_serial_port adc_serial_port_chk #(
  .SLEEP_CYCLES(SLEEP_CYCLES),
  .WAKE_CYCLES (WAKE_CYCLES)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .sclkIn   (sclkIn),
  .sdoData  (sdoData),
  .sdoEn    (sdoEn),
  .sleeping (sleeping),
  .filtReset(filtReset)
);

// File: tb/adc_serial_port_test.sv
`timescale 1ns/1ps
module adc_serial_port_test;
  localparam int SLEEP_T = 40;
  localparam int WAKE_T  = 10;
  localparam int NVEC    = 6;
  localparam logic [21:0] VECS [NVEC] = '{
    {2'b00, 20'h12345}, {2'b10, 20'hFFFFF}, {2'b01, 20'h80000},
    {2'b11, 20'h00001}, {2'b00, 20'h7FFFF}, {2'b10, 20'h5A5A5}};

  logic clk = 1'b0, rstN = 1'b0, convDone = 1'b0, ovr = 1'b0, osc = 1'b0;
  logic [19:0] data = '0;
  logic csN = 1'b1, sclk = 1'b0;
  logic sdo, en, slp, frst, sdo16, en16, slp16, frst16;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  adc_serial_port #(.DATA_W(20), .SLEEP_CYCLES(SLEEP_T), .WAKE_CYCLES(WAKE_T)) uut (
    .clk(clk), .rstN(rstN), .convDone(convDone), .ovrFlag(ovr), .oscFlag(osc),
    .convData(data), .csN(csN), .sclkIn(sclk), .sdoData(sdo), .sdoEn(en),
    .sleeping(slp), .filtReset(frst));

  adc_serial_port #(.DATA_W(16), .SLEEP_CYCLES(SLEEP_T), .WAKE_CYCLES(WAKE_T)) uut16 (
    .clk(clk), .rstN(rstN), .convDone(convDone), .ovrFlag(ovr), .oscFlag(osc),
    .convData(data[15:0]), .csN(csN), .sclkIn(sclk), .sdoData(sdo16), .sdoEn(en16),
    .sleeping(slp16), .filtReset(frst16));

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] word20(logic [21:0] v);
    return {1'b0, v[21], v[20], 1'b0, v[19:0]};
  endfunction

  function automatic logic [23:0] word16(logic [21:0] v);
    return {1'b0, v[21], v[20], 1'b0, 4'b0, v[15:0]};
  endfunction

  task automatic conv(logic [21:0] v);
    ovr = v[21]; osc = v[20]; data = v[19:0];
    convDone = 1'b1; tick();
    convDone = 1'b0; tick(2);
  endtask

  // shift out nbits; captured MSB first into w/w16
  task automatic readBits(int nbits, output logic [23:0] w, output logic [23:0] w16);
    w = '0; w16 = '0;
    for (int i = 0; i < nbits; i++) begin
      w[23-i] = sdo; w16[23-i] = sdo16;
      tick(8); sclk = 1'b1; tick(8); sclk = 1'b0; tick(8);
    end
  endtask

  task automatic fullRead(string req, logic [21:0] v);
    logic [23:0] w, w16;
    check(sdo == 1'b0 && sdo16 == 1'b0, {req, "/R4 ready low"}, {sdo, sdo16}, 0);
    readBits(24, w, w16);
    check(w == word20(v), {req, "/R2 word"}, w, word20(v));
    check(w16 == word16(v), {req, "/R3 word16"}, w16, word16(v));
    check(sdo == 1'b1, {req, "/R5 high after read"}, sdo, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] w, w16;
    tick(3);
    // R12: reset state
    check(sdo == 1 && en == 0 && slp == 0 && frst == 0, "R12 reset outputs",
          {sdo, en, slp, frst}, 4'b1000);
    rstN = 1'b1; tick(3);
    check(sdo == 1 && slp == 0, "R12 after release", {sdo, slp}, 2'b10);
    csN = 1'b0; tick(4);
    check(en == 1'b1, "R1 enable with cs low", en, 1);
    // R11: three unsettled conversions withheld
    for (int k = 0; k < 3; k++) begin
      conv(22'h3_55555);
      check(sdo == 1'b1, "R11 unsettled withheld", sdo, 1);
    end
    // vector table walk
    for (int k = 0; k < NVEC; k++) begin
      conv(VECS[k]);
      fullRead("R11/vec", VECS[k]);
      tick(20);
      check(sdo == 1'b1, "R5 stays high", sdo, 1);
    end
    // R8: unread word replaced
    conv(VECS[0]); conv(VECS[1]);
    fullRead("R8 replace", VECS[1]);
    // R6: new conversion during read discarded
    conv(VECS[2]);
    readBits(5, w, w16);
    conv(VECS[3]);
    begin
      logic [23:0] rest, rest16;
      readBits(19, rest, rest16);
      w[18:0] = rest[23:5];
      check(w == word20(VECS[2]), "R6 old word completes", w, word20(VECS[2]));
    end
    tick(10);
    check(sdo == 1'b1, "R6 overlapping word lost", sdo, 1);
    // R7: cs high mid-read abandons
    conv(VECS[4]);
    readBits(5, w, w16);
    csN = 1'b1; tick(4);
    check(en == 1'b0, "R1 enable with cs high", en, 0);
    csN = 1'b0; tick(4);
    check(sdo == 1'b1, "R7 abandoned word gone", sdo, 1);
    conv(VECS[5]);
    fullRead("R7 next word", VECS[5]);
    // R9: sleep drops held word, ignores conversions
    conv(VECS[0]);
    check(sdo == 1'b0, "R9 word held before sleep", sdo, 0);
    sclk = 1'b1; tick(SLEEP_T + 10);
    check(slp == 1'b1, "R9 asleep", slp, 1);
    check(sdo == 1'b1, "R9 held word dropped", sdo, 1);
    conv(VECS[1]);
    check(sdo == 1'b1, "R9 conversion ignored asleep", sdo, 1);
    // R10: wake with single filter reset pulse
    begin
      int pulses = 0;
      sclk = 1'b0;
      for (int k = 0; k < WAKE_T + 20; k++) begin
        tick();
        if (frst) pulses++;
      end
      check(pulses == 1, "R10 one filter reset pulse", pulses, 1);
      check(slp == 1'b0, "R10 awake", slp, 0);
    end
    // R11 after wake
    for (int k = 0; k < 3; k++) begin
      conv(VECS[2]);
      check(sdo == 1'b1, "R11 unsettled after wake", sdo, 1);
    end
    conv(VECS[3]);
    fullRead("R11 fourth after wake", VECS[3]);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule